// File: doc/BRIEF.md
# Six-Channel DMA Bus Arbiter

This block decides which of six DMA channel requesters may use one shared data bus. Each channel raises a request line. A channel is eligible only when four things hold at once: it is requesting, its own enable bit is set, its power-down group is not switched off, and the global controller enable is high. From the eligible set the arbiter picks one channel and raises its bit in a one-hot grant vector, together with a valid flag. The grant stays in place until the bus owner signals completion on a done input.

A scheme-select input picks one of two policies. Fixed priority always favours the lowest channel number and keeps no history. Rotating priority keeps a pointer that moves to the channel just above each completed winner, so busy channels take turns. The scheme can be changed at run time, and a change is applied at the next arbitration. Channels are powered down in two groups of unequal size: channels 0 to 3 form one group and channels 4 and 5 form the other.

Top module: `dma_bus_arbiter`

## Requirements
- R1: At most one bit of `grant` is set. `grant_vld` is high exactly when one bit of `grant` is set.
- R2: A channel can be granted only while its `req` bit and its `ch_en` bit are both 1. A channel whose `ch_en` bit is 0 is skipped, even when it would otherwise win.
- R3: While `ctrl_en` is 0, no new grant is issued.
- R4: `grp_off[0]`=1 masks channels 0 to 3. `grp_off[1]`=1 masks channels 4 and 5. With `grp_off`=2'b11, no grant is issued.
- R5: With `sched_rr`=0 (fixed), the eligible channel with the lowest number wins, whatever was granted before.
- R6: With `sched_rr`=1 (rotating), the search starts at the rotation pointer and runs upward, wrapping from channel 5 to channel 0. When a grant completes, the pointer moves to the winner's number plus one, modulo 6.
- R7: When the arbiter is idle and at least one channel is eligible, the grant appears at the next rising clock edge.
- R8: While `grant_vld` is high and `bus_done` is 0, `grant` keeps its value whatever the other inputs do.
- R9: `bus_done`=1 while a grant is active clears the grant at the next edge. The arbiter then stays idle for one cycle before it can grant again. `bus_done` is ignored while the arbiter is idle.
- R10: A change of `sched_rr` during an active grant leaves that grant unchanged. The new scheme applies at the next arbitration.
- R11: A channel that requests alone is granted under both schemes, wherever the rotation pointer stands.
- R12: A synchronous reset (`rst`=1) clears the grant and sets the rotation pointer to channel 0, so the first rotating collision after reset goes to the lowest eligible channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_en | input | 1 | Global controller enable |
| sched_rr | input | 1 | Priority scheme: 1 = rotating, 0 = fixed |
| grp_off | input | 2 | Group power-down: bit 0 masks channels 0-3, bit 1 masks channels 4-5 |
| ch_en | input | 6 | Per-channel enable |
| req | input | 6 | Per-channel bus request |
| bus_done | input | 1 | Current bus owner finished its transfer |
| grant | output | 6 | One-hot bus grant, bit n = channel n |
| grant_vld | output | 1 | A grant is active |

## Verification
The same request pattern, with channels 2, 3 and 5 requesting, is applied several times in a row. Under fixed priority it must give the same winner every time, and under rotation it must step 3, 5, 2. This separates a pointer that tracks the last winner from one that does not, and it exercises the wrap from 5 back to 0. Patterns with one group off, both groups off, the global enable low, or a single channel's enable cleared show whether the masks line up with the right channel numbers. A lone requester that sits below the pointer confirms that the search wraps around. Directed sequences flip the inputs and the scheme during a held grant, request through the idle gap after completion, and reset while the pointer is not at channel 0.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int ARB_CH    = 6;
  localparam int ARB_IDX_W = $clog2(ARB_CH);

  typedef logic [ARB_CH-1:0]    ch_vec_t;
  typedef logic [ARB_IDX_W-1:0] ch_idx_t;

  typedef enum logic {
    SCHED_FIXED  = 1'b0,
    SCHED_ROTATE = 1'b1
  } sched_e;

  // First eligible channel found when searching upward from 'start', wrapping.
  function automatic ch_vec_t pick_from(ch_vec_t elig, ch_idx_t start);
    ch_vec_t res;
    logic    hit;
    int      idx;
    res = '0;
    hit = 1'b0;
    for (int i = 0; i < ARB_CH; i++) begin
      idx = int'(start) + i;
      if (idx >= ARB_CH) idx = idx - ARB_CH;
      if (!hit && elig[idx[ARB_IDX_W-1:0]]) begin
        res[idx[ARB_IDX_W-1:0]] = 1'b1;
        hit = 1'b1;
      end
    end
    return res;
  endfunction

  // Index of the set bit of a one-hot vector (0 when empty).
  function automatic ch_idx_t onehot_idx(ch_vec_t v);
    ch_idx_t r;
    r = '0;
    for (int i = 0; i < ARB_CH; i++) begin
      if (v[i]) r = ch_idx_t'(i);
    end
    return r;
  endfunction

  // Channel above 'i', wrapping from the top channel back to 0.
  function automatic ch_idx_t idx_after(ch_idx_t i);
    if (i == ch_idx_t'(ARB_CH - 1)) return '0;
    return i + ch_idx_t'(1);
  endfunction

endpackage

// File: rtl/dma_arb_gate.sv
module dma_arb_gate
  import dma_arb_pkg::*;
#(
  parameter int GRP0_SIZE = 4
) (
  input  logic       ctrl_en,
  input  logic [1:0] grp_off,
  input  ch_vec_t    ch_en,
  input  ch_vec_t    req,
  output ch_vec_t    elig
);

  for (genvar c = 0; c < ARB_CH; c++) begin : g_chan
    localparam int GRP = (c < GRP0_SIZE) ? 0 : 1;
    assign elig[c] = ctrl_en & req[c] & ch_en[c] & ~grp_off[GRP];
  end

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
(
  input  ch_vec_t elig,
  input  sched_e  sched,
  input  ch_idx_t ptr,
  output ch_vec_t win,
  output logic    win_any
);

  ch_vec_t win_fixed;
  ch_vec_t win_rot;

  always_comb begin
    win_fixed = pick_from(elig, '0);
    win_rot   = pick_from(elig, ptr);
    win       = (sched == SCHED_ROTATE) ? win_rot : win_fixed;
  end

  assign win_any = |elig;

endmodule

// File: rtl/dma_arb_hist.sv
module dma_arb_hist
  import dma_arb_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    adv,
  input  ch_idx_t last_idx,
  output ch_idx_t ptr
);

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= idx_after(last_idx);
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(ptr) < ARB_CH);                                             // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr));                                          // R6
  AST_PTR_RESET: assert property (@(posedge clk)
    rst |=> ptr == '0);                                              // R12

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int GRP0_SIZE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_en,
  input  logic              sched_rr,
  input  logic [1:0]        grp_off,
  input  logic [ARB_CH-1:0] ch_en,
  input  logic [ARB_CH-1:0] req,
  input  logic              bus_done,
  output logic [ARB_CH-1:0] grant,
  output logic              grant_vld
);

  ch_vec_t elig;
  ch_vec_t win;
  logic    win_any;
  ch_idx_t ptr;
  sched_e  sched;
  logic    done_evt;
  logic    launch_evt;

  assign sched      = sched_e'(sched_rr);
  assign done_evt   = grant_vld & bus_done;
  assign launch_evt = ~grant_vld & win_any;

  dma_arb_gate #(.GRP0_SIZE(GRP0_SIZE)) u_gate (
    .ctrl_en (ctrl_en),
    .grp_off (grp_off),
    .ch_en   (ch_en),
    .req     (req),
    .elig    (elig)
  );

  dma_arb_pick u_pick (
    .elig    (elig),
    .sched   (sched),
    .ptr     (ptr),
    .win     (win),
    .win_any (win_any)
  );

  dma_arb_hist u_hist (
    .clk      (clk),
    .rst      (rst),
    .adv      (done_evt),
    .last_idx (onehot_idx(grant)),
    .ptr      (ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant     <= '0;
      grant_vld <= 1'b0;
    end else if (done_evt) begin
      grant     <= '0;
      grant_vld <= 1'b0;
    end else if (launch_evt) begin
      grant     <= win;
      grant_vld <= 1'b1;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> $onehot(grant));                                   // R1
  AST_GRANT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !grant_vld |-> grant == '0);                                     // R1
  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    !grant_vld |=> (grant & ~$past(elig)) == '0);                    // R2
  AST_CTRL_OFF: assert property (@(posedge clk) disable iff (rst)
    (!grant_vld && !ctrl_en) |=> !grant_vld);                        // R3
  AST_GROUPS_OFF: assert property (@(posedge clk) disable iff (rst)
    (!grant_vld && grp_off == 2'b11) |=> !grant_vld);                // R4
  AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (rst)
    (!grant_vld && !sched_rr && elig != '0)
      |=> grant == ($past(elig) & (~$past(elig) + 1'b1)));           // R5
  AST_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    (!grant_vld && elig != '0) |=> grant_vld);                       // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && !bus_done) |=> grant_vld && $stable(grant));       // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && bus_done) |=> !grant_vld);                         // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !grant_vld && grant == '0);                              // R12

endmodule

// File: tb/dma_bus_arbiter_tb.sv
module dma_bus_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_en = 1'b0;
  logic       sched_rr = 1'b0;
  logic [1:0] grp_off = 2'b00;
  logic [5:0] ch_en = '0;
  logic [5:0] req = '0;
  logic       bus_done = 1'b0;
  logic [5:0] grant;
  logic       grant_vld;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_bus_arbiter dut_i (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .sched_rr(sched_rr),
    .grp_off(grp_off), .ch_en(ch_en), .req(req), .bus_done(bus_done),
    .grant(grant), .grant_vld(grant_vld)
  );

  // {req tag, sched_rr, ctrl_en, grp_off, ch_en, req, expected grant}
  localparam int NV = 15;
  localparam logic [25:0] VEC [NV] = '{
    {4'd5,  1'b0, 1'b1, 2'b00, 6'h3F,      6'b101100, 6'b000100}, // R5 fixed
    {4'd6,  1'b1, 1'b1, 2'b00, 6'h3F,      6'b101100, 6'b001000}, // R6 ptr 3
    {4'd6,  1'b1, 1'b1, 2'b00, 6'h3F,      6'b101100, 6'b100000}, // R6 ptr 4
    {4'd6,  1'b1, 1'b1, 2'b00, 6'h3F,      6'b101100, 6'b000100}, // R6 wrap
    {4'd5,  1'b0, 1'b1, 2'b00, 6'h3F,      6'b110001, 6'b000001}, // R5
    {4'd11, 1'b1, 1'b1, 2'b00, 6'h3F,      6'b000001, 6'b000001}, // R11 below ptr
    {4'd4,  1'b1, 1'b1, 2'b01, 6'h3F,      6'b110001, 6'b010000}, // R4 low group off
    {4'd4,  1'b1, 1'b1, 2'b10, 6'h3F,      6'b111111, 6'b000001}, // R4 high group off
    {4'd4,  1'b1, 1'b1, 2'b11, 6'h3F,      6'b111111, 6'b000000}, // R4 both off
    {4'd3,  1'b1, 1'b0, 2'b00, 6'h3F,      6'b111111, 6'b000000}, // R3
    {4'd2,  1'b1, 1'b1, 2'b00, 6'b111101,  6'b111111, 6'b000100}, // R2 ch1 off
    {4'd2,  1'b0, 1'b1, 2'b00, 6'b111100,  6'b001110, 6'b000100}, // R2 fixed
    {4'd6,  1'b1, 1'b1, 2'b00, 6'h3F,      6'b000011, 6'b000001}, // R6 wrap
    {4'd11, 1'b0, 1'b1, 2'b00, 6'h3F,      6'b100000, 6'b100000}, // R11 fixed
    {4'd11, 1'b1, 1'b1, 2'b00, 6'h3F,      6'b100000, 6'b100000}  // R11 rotating
  };

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_grant();
    @(negedge clk); bus_done = 1'b1; req = '0;
    @(posedge clk); #1;
    check("R9", {grant_vld, grant[4:0]}, 6'b0);
    @(negedge clk); bus_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    check("R12", grant, 6'b0);                           // R12 reset state
    check("R12", {5'b0, grant_vld}, 6'b0);
    @(negedge clk); rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      sched_rr = VEC[v][21]; ctrl_en = VEC[v][20]; grp_off = VEC[v][19:18];
      ch_en = VEC[v][17:12]; req = VEC[v][11:6];
      @(posedge clk); #1;                                // R7 one-edge latency
      check($sformatf("R%0d", VEC[v][25:22]), grant, VEC[v][5:0]);
      check("R1", {5'b0, grant_vld}, {5'b0, |VEC[v][5:0]});
      finish_grant();
    end

    // R8: grant held while every other input changes
    @(negedge clk);
    sched_rr = 1'b1; ctrl_en = 1'b1; grp_off = 2'b00; ch_en = 6'h3F; req = 6'h3F;
    @(posedge clk); #1;
    check("R6", grant, 6'b000001);
    @(negedge clk); req = '0; sched_rr = 1'b0; ch_en = '0; grp_off = 2'b11; ctrl_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check("R8", grant, 6'b000001);
    end
    // R9: idle gap even with requests pending
    @(negedge clk);
    bus_done = 1'b1; ctrl_en = 1'b1; grp_off = 2'b00; ch_en = 6'h3F; req = 6'h3F; sched_rr = 1'b1;
    @(posedge clk); #1;
    check("R9", {grant_vld, grant[4:0]}, 6'b0);
    @(negedge clk); bus_done = 1'b0;
    @(posedge clk); #1;
    check("R6", grant, 6'b000010);
    // R10: scheme change during a grant
    @(negedge clk); sched_rr = 1'b0;
    repeat (2) @(posedge clk); #1;
    check("R10", grant, 6'b000010);
    @(negedge clk); bus_done = 1'b1;
    @(negedge clk); bus_done = 1'b0;
    @(posedge clk); #1;
    check("R10", grant, 6'b000001);
    // R12: reset while the pointer is off channel 0
    @(negedge clk); bus_done = 1'b1; sched_rr = 1'b1;
    @(negedge clk); bus_done = 1'b0;
    @(posedge clk); #1;
    check("R6", grant, 6'b000010);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R12", {grant_vld, grant[4:0]}, 6'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R12", grant, 6'b000001);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule